// File: doc/BRIEF.md
# Range-Checked Data Memory

This block is the data store of a single-cycle processor model. It holds a parameterised number of 64-bit words and is addressed by a 64-bit byte address. A read presents the addressed word on the output in the same cycle. A write is committed at the rising clock edge. The low three address bits select a byte within a word and are ignored, so every access touches one whole word.

Any access whose eight bytes would not fit inside the implemented storage raises an error flag in the same cycle. Such an access never changes any stored word. Its read data is forced to zero, so an out-of-range address cannot wrap around onto a real word.

A synchronous active-high reset makes every word read as zero. The processor model can then start from a known memory image without a preload path.

Top module: `dmem_top`

## Requirements
- R1: In the first cycle after reset is released, every in-range read returns zero with `err` low.
- R2: With `rd_en` high, `wr_en` low and an in-range address, `rdata` shows the stored word in the same cycle and `err` is 0.
- R3: A write with `wr_en` high to an in-range address stores `wdata` at the next rising clock edge. Before that edge a read of the same word returns the old contents, and after the edge it returns the new word.
- R4: When `rd_en` or `wr_en` is high and `addr` is greater than WORDS*8-8, `err` is 1 in the same cycle and `rdata` is 0.
- R5: A write with an out-of-range address changes no stored word, including the word its address would select if it wrapped.
- R6: With `wr_en` low, a change of `wdata` or `addr` changes no stored word.
- R7: Address bits [2:0] are ignored: every address from 8k to 8k+7 selects word k.
- R8: Address WORDS*8-8 is valid and selects the last word. Addresses WORDS*8-7 and 64'hFFFF_FFFF_FFFF_FFF8 are invalid, with no wrap-around in the range check.
- R9: With both `rd_en` and `wr_en` low, `err` is 0 and `rdata` is 0.
- R10: While `rst` is high, writes are ignored. Once `rst` is released, words written before the reset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 64 | Byte address of the access |
| wdata | input | 64 | Word to be written |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rdata | output | 64 | Read word, zero on error or when no read is requested |
| err | output | 1 | Address out of range for the requested access |

## Verification
The read path is combinational, so a wrong stored word or a wrong valid bit shows on `rdata` in the same cycle that the word is addressed. An address-decode fault shows on `err` at once. A write that commits on the wrong edge, or that leaks through on an out-of-range address, only becomes visible when a later read selects the affected word. For this reason the directed tests read back both the last word and word 0 after every rejected write. An incomplete reset clear shows as non-zero data on the first read after reset is released.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int WORD_BYTES = 8;
  localparam int BYTE_SHIFT = 3;
  localparam int ADDR_W     = 64;
  localparam int DATA_W     = 64;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dmem_addr_check.sv
module dmem_addr_check
  import dmem_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  addr_t                      addr,
  input  logic                       rd_en,
  input  logic                       wr_en,
  output logic                       in_range,
  output logic                       err,
  output logic [$clog2(WORDS)-1:0]   idx
);
  localparam int    IW    = $clog2(WORDS);
  localparam addr_t LIMIT = ADDR_W'((WORDS - 1) * WORD_BYTES);

  // Compare against the last legal start address, so addr+8 can never overflow.
  assign in_range = (addr <= LIMIT);
  assign err      = (rd_en | wr_en) & ~in_range;
  assign idx      = addr[BYTE_SHIFT +: IW];
endmodule

// File: rtl/dmem_word_store.sv
module dmem_word_store
  import dmem_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  word_t                    wdata,
  output word_t                    rdata_raw
);
  localparam int IW = $clog2(WORDS);

  // Data array without reset, so it can map to RAM resources.
  word_t            mem [WORDS];
  // One written-since-reset flag per word; only these flops are reset.
  logic [WORDS-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld      <= '0;
    else if (we) vld[idx] <= 1'b1;
  end

  assign rdata_raw = vld[idx] ? mem[idx] : '0;

  logic unused_iw;
  assign unused_iw = (IW == 0);
endmodule

// File: rtl/dmem_top.sv
module dmem_top
  import dmem_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] addr,
  input  logic [63:0] wdata,
  input  logic        rd_en,
  input  logic        wr_en,
  output logic [63:0] rdata,
  output logic        err
);
  localparam int IW = $clog2(WORDS);

  logic          in_range;
  logic [IW-1:0] idx;
  logic          we;
  word_t         raw;

  dmem_addr_check #(.WORDS(WORDS)) u_chk_addr (
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .in_range (in_range),
    .err      (err),
    .idx      (idx)
  );

  assign we = wr_en & in_range & ~rst;

  dmem_word_store #(.WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .idx       (idx),
    .wdata     (wdata),
    .rdata_raw (raw)
  );

  assign rdata = (rd_en & in_range) ? raw : '0;
endmodule

// File: rtl/dmem_chk.sv
module dmem_chk #(
  parameter int WORDS = 1024
) (
  input logic        clk,
  input logic        rst,
  input logic [63:0] addr,
  input logic [63:0] wdata,
  input logic        rd_en,
  input logic        wr_en,
  input logic [63:0] rdata,
  input logic        err
);
  localparam logic [63:0] LIMIT = 64'((WORDS - 1) * 8);

  p_err_zero_data_r4: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == 64'd0));

  p_oob_flag_r4: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && (addr > LIMIT)) |-> err);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |-> (!err && rdata == 64'd0));

  p_write_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(err) && rd_en && !err
     && addr == $past(addr)) |-> (rdata == $past(wdata)));

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && rd_en && !err) |-> (rdata == 64'd0));
endmodule

bind dmem_top dmem_chk #(.WORDS(WORDS)) u_dmem_chk (
  .clk   (clk),
  .rst   (rst),
  .addr  (addr),
  .wdata (wdata),
  .rd_en (rd_en),
  .wr_en (wr_en),
  .rdata (rdata),
  .err   (err)
);

// File: tb/dmem_top_tb.sv
module dmem_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 1024;
  localparam logic [63:0] MEM_BYTES = 64'(WORDS * 8);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] rdata;
  logic        err;

  int n_run  = 0;
  int n_fail = 0;

  dmem_top #(.WORDS(WORDS)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] pat(input int k);
    return 64'hC3A5_0000_0000_0000 ^ (64'(k) * 64'h0001_0203_0405_0607);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [63:0] a,
                    input logic [63:0] exp_d, input logic exp_e);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    check({req, " data"}, rdata, exp_d);
    check({req, " err"}, 64'(err), 64'(exp_e));
    rd_en = 1'b0;
  endtask

  task automatic t_reset_state;
    rd("R1 word0", 64'd0, 64'd0, 1'b0);
    rd("R1 word5", 64'd40, 64'd0, 1'b0);
    rd("R1 last", MEM_BYTES - 8, 64'd0, 1'b0);
  endtask

  task automatic t_basic_rw;
    for (int k = 0; k < 6; k++) wr(64'(k * 8 * 37), pat(k));
    wr(MEM_BYTES - 8, pat(99));
    for (int k = 0; k < 6; k++) rd("R2 readback", 64'(k * 8 * 37), pat(k), 1'b0);
    rd("R8 last word valid", MEM_BYTES - 8, pat(99), 1'b0);
  endtask

  task automatic t_edge_commit;
    @(negedge clk);
    addr = 64'd56; wdata = pat(7); wr_en = 1'b1; rd_en = 1'b1;
    #1;
    check("R3 old before edge", rdata, 64'd0);
    @(posedge clk);
    #1;
    check("R3 new after edge", rdata, pat(7));
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_out_of_range;
    rd("R4 at size", MEM_BYTES, 64'd0, 1'b1);
    rd("R8 size-7", MEM_BYTES - 7, 64'd0, 1'b1);
    rd("R8 top addr", 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 1'b1);
  endtask

  task automatic t_oob_write;
    @(negedge clk);
    addr = MEM_BYTES; wdata = 64'hDEAD_BEEF_0BAD_F00D; wr_en = 1'b1; rd_en = 1'b0;
    #1;
    check("R4 write err", 64'(err), 64'd1);
    @(negedge clk);
    addr = 64'hFFFF_FFFF_FFFF_FFF8;
    @(negedge clk);
    wr_en = 1'b0;
    rd("R5 word0 kept", 64'd0, pat(0), 1'b0);
    rd("R5 last kept", MEM_BYTES - 8, pat(99), 1'b0);
  endtask

  task automatic t_no_enable;
    @(negedge clk);
    addr = 64'd296; wdata = 64'h1111_2222_3333_4444; wr_en = 1'b0; rd_en = 1'b0;
    #1;
    check("R9 idle err", 64'(err), 64'd0);
    check("R9 idle data", rdata, 64'd0);
    @(negedge clk);
    addr = MEM_BYTES + 64;
    #1;
    check("R9 idle oob err", 64'(err), 64'd0);
    @(negedge clk);
    rd("R6 word1 kept", 64'd296, pat(1), 1'b0);
  endtask

  task automatic t_low_bits;
    wr(64'd77, pat(42));
    rd("R7 offset0", 64'd72, pat(42), 1'b0);
    rd("R7 offset7", 64'd79, pat(42), 1'b0);
  endtask

  task automatic t_reset_clear;
    @(negedge clk);
    rst = 1'b1;
    addr = 64'd16; wdata = pat(5); wr_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b0;
    rd("R10 cleared", 64'd72, 64'd0, 1'b0);
    rd("R10 write in reset ignored", 64'd16, 64'd0, 1'b0);
    rd("R10 last cleared", MEM_BYTES - 8, 64'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_basic_rw();
    t_edge_commit();
    t_out_of_range();
    t_oob_write();
    t_no_enable();
    t_low_bits();
    t_reset_clear();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule